// File: doc/BRIEF.md
# Multi-Channel Temperature Sample Sequencer

This block drives a temperature conversion front end that can look at one on-die sensor or at one of four remote sensors. A single control word chooses the source, starts and stops conversion, sets the spacing between conversions and the number of samples averaged per result, and can hold the block in a soft-reset state. The block tells the front end which logical channel to convert and whether it is running. At each sample instant it takes a signed 10-bit raw code, averages a power-of-two number of codes, and publishes the mean with a valid flag in a status word.

Moving to a different source stops conversion and drops the valid flag at once. The flag comes back only after a fixed settle delay followed by a complete averaged set of codes from the new source, so software never reads data from the previous source. The settle delay and the base sample spacing are counted in clock cycles and set by parameters.

Top module: `tsense_seq`

## Requirements
- R1: After a synchronous active-low reset, the control readback, the status word, `src_run` and `src_chan` are all zero.
- R2: The control word has these fields: bit 0 start, bit 1 enable, bit 2 soft reset, bits 4:3 mode, bits 6:5 remote channel, bits 8:7 spacing select, bits 11:9 averaging exponent N, bit 12 averaging bypass. `ctrl_rdata` returns the last word written.
- R3: Conversion runs (`src_run` high) only while start=1, enable=1, soft reset=0 and mode is 0 or 2. In any other state `src_run` is low and the valid flag is low.
- R4: `src_chan` is 0 when mode is 0. When mode is 2 it is the channel field plus one.
- R5: A write that starts conversion from a stopped state, or that changes the logical channel, clears valid at the write edge. Valid rises exactly SETTLE_CYC + 2^N·P cycles after that write edge.
- R6: The sample spacing P is PERIOD_BASE shifted left by the spacing select.
- R7: Each result is the sum of 2^N sign-extended codes shifted arithmetically right by N, which is floor division. With bypass set, one code is used and N is ignored.
- R8: Status bits 9:0 hold the result in two's complement, and bit 10 holds valid.
- R9: A write that keeps the same running source leaves valid and the result as they were, discards the partial set, and delivers the next result 2^N·P cycles after the write.
- R10: While the soft reset bit is stored, the status word is zero and `src_run` is low, and the control fields still read back. Clearing the bit restarts conversion with the full settle delay.
- R11: Clearing start drops valid and `src_run` at the write edge.
- R12: Once valid, a new result is published every 2^N·P cycles, each computed from its own fresh set of codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 13 | Control word to write |
| ctrl_rdata | output | 13 | Stored control word |
| stat_rdata | output | 11 | Status word: valid flag and averaged result |
| src_chan | output | 3 | Logical channel the front end should convert (0 = on-die) |
| src_run | output | 1 | Front end conversion enable |
| adc_code | input | 10 | Signed raw code from the front end, taken at sample instants |

## Verification
If the settle counter or the spacing counter holds a wrong value, the valid flag rises one or more cycles away from its computed edge after any source change. The cycle-exact latency check catches this on the first averaged set. If the accumulator or the sample count is wrong, the first published mean differs from the floor of the expected sum. The codes change every cycle, so taking the wrong sample instant also corrupts that first value. Stale state carried across a channel switch, a stop or a soft reset shows up as a valid flag within the settle window, or as a result that mixes codes from the old source, and both appear within one set.

// File: rtl/tsq_pkg.sv
// Shared types for the temperature sample sequencer.
// Assumes a 10-bit signed raw code and a 13-bit control word.
package tsq_pkg;
    localparam int CODE_W  = 10;
    localparam int AVG_FW  = 3;
    localparam int OSR_FW  = 2;
    localparam int LCH_W   = 3;
    localparam int CTRL_W  = 13;
    localparam int STAT_W  = CODE_W + 1;
    localparam int AVG_MAX = (1 << AVG_FW) - 1;

    localparam logic [1:0] MODE_ONDIE  = 2'd0;
    localparam logic [1:0] MODE_REMOTE = 2'd2;

    // Control word, most significant field first
    typedef struct packed {
        logic              avg_byp;
        logic [AVG_FW-1:0] avg_log;
        logic [OSR_FW-1:0] spacing;
        logic [1:0]        rchan;
        logic [1:0]        mode;
        logic              soft_rst;
        logic              enable;
        logic              start;
    } ctrl_t;

    typedef enum logic [1:0] {PH_IDLE, PH_SETTLE, PH_RUN} phase_e;

    // Logical channel: 0 for the on-die sensor, remote field plus one otherwise
    function automatic logic [LCH_W-1:0] logical_chan(input ctrl_t c);
        return (c.mode == MODE_REMOTE) ? ({1'b0, c.rchan} + 3'd1) : '0;
    endfunction

    // A control word that lets conversion run
    function automatic logic is_running(input ctrl_t c);
        return c.start & c.enable & ~c.soft_rst &
               ((c.mode == MODE_ONDIE) | (c.mode == MODE_REMOTE));
    endfunction
endpackage

// File: rtl/tsq_ctrl_reg.sv
// Control register and write classifier.
// Holds the control word and tells whether the write in this cycle changes
// the source (full restart with settle) or keeps it (restart of the set only).
// Assumes one write per cycle at most.
module tsq_ctrl_reg
    import tsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_nx,
    output logic              src_chg,
    output logic              same_src
);
    ctrl_t wr_c;
    logic  run_old;
    logic  run_new;

    // Classify the incoming write against the stored word
    always_comb begin
        wr_c     = ctrl_t'(wdata);
        ctrl_nx  = we ? wr_c : ctrl_q;
        run_old  = is_running(ctrl_q);
        run_new  = is_running(wr_c);
        src_chg  = we & run_new &
                   (~run_old | (logical_chan(wr_c) != logical_chan(ctrl_q)));
        same_src = we & run_new & ~src_chg;
    end

    // Store the control word
    always_ff @(posedge clk) begin
        if (!rst_n)  ctrl_q <= '0;
        else if (we) ctrl_q <= wr_c;
    end
endmodule

// File: rtl/tsq_timer.sv
// Settle and sample-spacing timer.
// After a source change it counts SETTLE_CYC cycles, then emits one tick
// every PERIOD_BASE << spacing cycles. Assumes both parameters are at least 1.
module tsq_timer
    import tsq_pkg::*;
#(
    parameter int SETTLE_CYC  = 3750000,
    parameter int PERIOD_BASE = 62500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_nx,
    input  logic              src_chg,
    input  logic              same_src,
    input  logic [OSR_FW-1:0] spacing,
    output phase_e            phase,
    output logic              tick
);
    localparam int PER_MAX = PERIOD_BASE << ((1 << OSR_FW) - 1);
    localparam int CNT_MAX = (SETTLE_CYC > PER_MAX) ? SETTLE_CYC : PER_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] period;
    logic             settle_done;

    // Decode the current spacing and the end conditions
    always_comb begin
        period      = CNT_W'(PERIOD_BASE) << spacing;
        tick        = (phase == PH_RUN) && (cnt == period - CNT_W'(1));
        settle_done = (cnt == CNT_W'(SETTLE_CYC - 1));
    end

    // Phase and counter sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (!run_nx) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (src_chg) begin
            phase <= PH_SETTLE;
            cnt   <= '0;
        end else if (same_src && phase == PH_RUN) begin
            cnt   <= '0;
        end else begin
            case (phase)
                PH_SETTLE: begin
                    if (settle_done) begin
                        phase <= PH_RUN;
                        cnt   <= '0;
                    end else begin
                        cnt   <= cnt + CNT_W'(1);
                    end
                end
                PH_RUN:  cnt <= tick ? '0 : cnt + CNT_W'(1);
                default: cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/tsq_avg.sv
// Power-of-two averager with valid generation.
// Sums 2^N sign-extended codes and publishes floor(sum / 2^N).
// Assumes the timer tick marks every sample instant.
module tsq_avg
    import tsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_nx,
    input  logic              run_nx,
    input  logic              src_chg,
    input  logic              same_src,
    input  logic              tick,
    input  logic              avg_byp,
    input  logic [AVG_FW-1:0] avg_log,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] result,
    output logic              valid
);
    localparam int ACC_W  = CODE_W + AVG_MAX;
    localparam int SCNT_W = AVG_MAX + 1;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] acc_sum;
    logic signed [ACC_W-1:0] acc_div;
    logic [AVG_FW-1:0]       shift;
    logic [SCNT_W-1:0]       nsamp;
    logic                    last;

    // Running sum, scaling and end-of-set detection
    always_comb begin
        shift   = avg_byp ? '0 : avg_log;
        acc_sum = acc + {{(ACC_W-CODE_W){code[CODE_W-1]}}, code};
        acc_div = acc_sum >>> shift;
        last    = (nsamp == SCNT_W'((1 << shift) - 1));
    end

    // Accumulate, publish and invalidate
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_nx) begin
            acc    <= '0;
            nsamp  <= '0;
            valid  <= 1'b0;
            result <= '0;
        end else if (!run_nx || src_chg) begin
            acc    <= '0;
            nsamp  <= '0;
            valid  <= 1'b0;
        end else if (same_src) begin
            acc    <= '0;
            nsamp  <= '0;
        end else if (tick) begin
            if (last) begin
                result <= acc_div[CODE_W-1:0];
                valid  <= 1'b1;
                acc    <= '0;
                nsamp  <= '0;
            end else begin
                acc    <= acc_sum;
                nsamp  <= nsamp + SCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/tsense_seq.sv
// Top of the temperature sample sequencer.
// Ties the control register, the timer and the averager together and
// presents the control and status words. Assumes adc_code is stable at
// each sample instant.
module tsense_seq
    import tsq_pkg::*;
#(
    parameter int SETTLE_CYC  = 3750000,
    parameter int PERIOD_BASE = 62500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic [STAT_W-1:0] stat_rdata,
    output logic [LCH_W-1:0]  src_chan,
    output logic              src_run,
    input  logic [CODE_W-1:0] adc_code
);
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_nx;
    logic              src_chg;
    logic              same_src;
    logic              run_nx;
    phase_e            phase;
    logic              tick;
    logic [CODE_W-1:0] result;
    logic              valid;

    tsq_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wdata    (ctrl_wdata),
        .ctrl_q   (ctrl_q),
        .ctrl_nx  (ctrl_nx),
        .src_chg  (src_chg),
        .same_src (same_src)
    );

    tsq_timer #(
        .SETTLE_CYC  (SETTLE_CYC),
        .PERIOD_BASE (PERIOD_BASE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_nx   (run_nx),
        .src_chg  (src_chg),
        .same_src (same_src),
        .spacing  (ctrl_q.spacing),
        .phase    (phase),
        .tick     (tick)
    );

    tsq_avg u_avg (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst_nx (ctrl_nx.soft_rst),
        .run_nx      (run_nx),
        .src_chg     (src_chg),
        .same_src    (same_src),
        .tick        (tick),
        .avg_byp     (ctrl_q.avg_byp),
        .avg_log     (ctrl_q.avg_log),
        .code        (adc_code),
        .result      (result),
        .valid       (valid)
    );

    // Drive the port-level views of the internal state
    always_comb begin
        run_nx     = is_running(ctrl_nx);
        ctrl_rdata = ctrl_q;
        stat_rdata = {valid, result};
        src_chan   = logical_chan(ctrl_q);
        src_run    = (phase != PH_IDLE);
    end
endmodule

// File: rtl/tsq_chk.sv
// Property checker for the temperature sample sequencer, bound to the top.
// Watches only port-level signals; a counter tracks the settle window.
module tsq_chk #(
    parameter int SETTLE_CYC = 3750000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_we,
    input logic [12:0] ctrl_rdata,
    input logic [10:0] stat_rdata,
    input logic [2:0]  src_chan,
    input logic        src_run
);
    localparam int HC_W = $clog2(SETTLE_CYC + 2);

    logic            prev_run;
    logic [2:0]      prev_chan;
    logic            restart_now;
    logic [HC_W-1:0] hold_cnt;

    // A restart is a rise of src_run or a channel change while running
    always_comb begin
        restart_now = src_run && (!prev_run || (src_chan != prev_chan));
    end

    // Cycles elapsed since the last observed restart, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_run  <= 1'b0;
            prev_chan <= '0;
            hold_cnt  <= HC_W'(SETTLE_CYC + 1);
        end else begin
            prev_run  <= src_run;
            prev_chan <= src_chan;
            if (restart_now)
                hold_cnt <= HC_W'(1);
            else if (hold_cnt <= HC_W'(SETTLE_CYC))
                hold_cnt <= hold_cnt + HC_W'(1);
        end
    end

    assert_idle_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !src_run |-> !stat_rdata[10]);

    assert_settle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_now || hold_cnt <= HC_W'(SETTLE_CYC)) |-> !stat_rdata[10]);

    assert_ondie_chan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_run && ctrl_rdata[4:3] == 2'd0) |-> src_chan == 3'd0);

    assert_chan_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctrl_we) |-> $stable(src_chan));

    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[2] |-> (stat_rdata == 11'd0 && !src_run));
endmodule

bind tsense_seq tsq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_rdata (ctrl_rdata),
    .stat_rdata (stat_rdata),
    .src_chan   (src_chan),
    .src_run    (src_run)
);

// File: tb/tb_tsense_seq.sv
// Self-checking bench: sweeps spacing and averaging exponents and checks
// the cycle-exact latency and the arithmetic mean against bench-side sums.
module tb_tsense_seq;
    localparam int S      = 20;
    localparam int PB     = 3;
    localparam int WD_CYC = 200000;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        we    = 1'b0;
    logic [12:0] wdata = '0;
    logic [9:0]  adc   = '0;
    logic [12:0] ctrl_rd;
    logic [10:0] stat;
    logic [2:0]  chan;
    logic        run;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tsense_seq #(.SETTLE_CYC(S), .PERIOD_BASE(PB)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (we),
        .ctrl_wdata (wdata),
        .ctrl_rdata (ctrl_rd),
        .stat_rdata (stat),
        .src_chan   (chan),
        .src_run    (run),
        .adc_code   (adc)
    );

    // Raw code the front end presents in cycle i for logical channel ch
    function automatic logic [9:0] gen(input int ch, input int i);
        int v;
        v = ((ch * 97 + i * 37) % 1024) - 512;
        return v[9:0];
    endfunction

    // Build a control word from its fields (R2 layout)
    function automatic logic [12:0] mk(input bit st, input bit en, input bit sr,
                                       input int mode, input int rch, input int sp,
                                       input int n, input bit byp);
        return {byp, 3'(n), 2'(sp), 2'(rch), 2'(mode), sr, en, st};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write a word and follow the given number of averaged sets cycle by cycle
    task automatic run_set(input logic [12:0] w, input bit settle, input int sets,
                           input string req);
        int lch, sh, per, m, off, total, holdbad;
        logic [10:0] st0;
        lch   = (w[4:3] == 2'd2) ? int'(w[6:5]) + 1 : 0;
        sh    = w[12] ? 0 : int'(w[11:9]);
        per   = PB << w[8:7];
        m     = 1 << sh;
        off   = settle ? S : 0;
        total = off + sets * m * per;
        holdbad = 0;
        st0   = stat;
        @(negedge clk);
        we = 1'b1;
        wdata = w;
        for (int i = 1; i <= total + 1; i++) begin
            @(negedge clk);
            we  = 1'b0;
            adc = gen(lch, i);
            if (i == 1)
                check(chan == 3'(lch) && run, "R4 logical channel on src_chan", int'(chan), lch);
            if (i - 1 < off + m * per) begin
                if (settle && stat[10]) holdbad++;
                if (!settle && stat != st0) holdbad++;
            end
            for (int s = 1; s <= sets; s++) begin
                if (i - 1 == off + s * m * per) begin
                    int sum;
                    int exp;
                    sum = 0;
                    for (int k = (s - 1) * m + 1; k <= s * m; k++)
                        sum += int'($signed(gen(lch, off + k * per)));
                    exp = sum >>> sh;
                    check(stat[10] && stat[9:0] == exp[9:0], req, int'(stat), int'(exp[9:0]) + 1024);
                end
            end
        end
        check(holdbad == 0, settle ? "R5 valid low until settle plus full set"
                                   : "R9 status kept during restarted set", holdbad, 0);
    endtask

    // Clear start and confirm the drop (R11)
    task automatic stop_it(input logic [12:0] w);
        @(negedge clk);
        we = 1'b1;
        wdata = w & ~13'h1;
        @(negedge clk);
        we = 1'b0;
        check(!stat[10] && !run, "R11 stop drops valid and src_run", int'({stat[10], run}), 0);
    endtask

    initial begin
        logic [12:0] w;
        logic [12:0] w2;
        logic [12:0] w3;
        repeat (5) @(negedge clk);
        check(ctrl_rd == 13'd0 && stat == 11'd0 && !run && chan == 3'd0,
              "R1 reset state", int'(stat), 0);
        rst_n = 1'b1;

        // R2 readback
        w = mk(0, 1, 0, 2, 3, 2, 5, 1);
        @(negedge clk); we = 1'b1; wdata = w;
        @(negedge clk); we = 1'b0;
        check(ctrl_rd == w, "R2 control readback", int'(ctrl_rd), int'(w));

        // R3 reserved mode and disabled block do not run
        @(negedge clk); we = 1'b1; wdata = mk(1, 1, 0, 1, 0, 0, 0, 0);
        @(negedge clk); we = 1'b0;
        repeat (S + 2 * PB + 4) @(negedge clk);
        check(!run && !stat[10], "R3 reserved mode stays idle", int'({stat[10], run}), 0);
        @(negedge clk); we = 1'b1; wdata = mk(1, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); we = 1'b0;
        repeat (S + 2 * PB + 4) @(negedge clk);
        check(!run && !stat[10], "R3 enable low stays idle", int'({stat[10], run}), 0);

        // R5 R6 R7 R8 sweep over spacing and averaging exponent
        for (int sp = 0; sp < 4; sp++) begin
            for (int n = 0; n < 8; n++) begin
                w = mk(1, 1, 0, (n % 3 == 0) ? 0 : 2, (sp + n) % 4, sp, n, 0);
                stop_it(w);
                run_set(w, 1'b1, 1, "R7 R6 R8 averaged result after settle");
            end
        end

        // R7 bypass ignores N
        w = mk(1, 1, 0, 2, 1, 1, 5, 1);
        stop_it(w);
        run_set(w, 1'b1, 3, "R7 bypass uses one code");

        // R12 consecutive sets
        w = mk(1, 1, 0, 0, 2, 0, 2, 0);
        stop_it(w);
        run_set(w, 1'b1, 4, "R12 consecutive sets");

        // R9 rewrite of the same source
        w2 = mk(1, 1, 0, 0, 1, 2, 3, 0);
        run_set(w2, 1'b0, 2, "R9 same-source rewrite");

        // R5 direct channel switch while running
        w3 = mk(1, 1, 0, 2, 3, 1, 1, 0);
        run_set(w3, 1'b1, 1, "R5 channel switch");

        // R10 soft reset
        @(negedge clk); we = 1'b1; wdata = w3 | 13'h4;
        @(negedge clk); we = 1'b0;
        repeat (3) @(negedge clk);
        check(ctrl_rd == (w3 | 13'h4), "R10 fields kept under soft reset", int'(ctrl_rd), int'(w3 | 13'h4));
        check(stat == 11'd0 && !run, "R10 status cleared under soft reset", int'(stat), 0);
        run_set(w3, 1'b1, 1, "R10 restart after soft reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule